// File: doc/BRIEF.md
# Frame-Relative Effective Address Generator

This unit takes the addressing-mode byte of one instruction and works out where its source operand lives. The result is a 32-bit memory address, the number of a register, or a note that a word immediate is the operand. Every address it forms is relative to a 16-bit frame pointer. Short addresses fall inside a 64K direct page, whose upper half-word comes from a direct-page register. The unit also reports how many operand words the instruction carries and how many cycles the access costs.

Three modes go through a pointer held in the direct page. For these the unit first puts the pointer's address on a request port and waits. When the surrounding memory (here, the testbench) acknowledges, it takes the returned 32-bit pointer and finishes the calculation. All other modes finish in the cycle after the start is accepted. Each result is announced by a one-cycle `done` pulse. The result outputs then hold until the next `done`.

Top module: `frame_ea_gen`

## Requirements
- R1: The mode byte is split as bits [7:6] index-register number, bits [5:3] mode, bits [2:0] select. Index register k is `idx_regs[16k+15:16k]`. A direct-page address is `{direct_page, offset}`, with the 16-bit offset wrapping modulo 2^16.
- R2: Handshake for direct modes (010, 011, 101, 110, 111): `done` is high in the cycle after a start is accepted. For pointer modes (000, 001, 100), `ptr_req` and `busy` rise in the cycle after the start. `ptr_addr` then holds steady until `ptr_ack` is sampled. `done` is high in the cycle after that, with `ptr_req` and `busy` low again.
- R3: A `start` that arrives while `busy` is high is ignored. The result that follows is still the one for the instruction first accepted, and mode byte, immediate and register inputs are taken at acceptance only.
- R4: The pointer address is `{direct_page, imm[15:0] + frame_ptr + idx}` for mode 000. It is `{direct_page, imm[15:0] + frame_ptr}` for modes 001 and 100.
- R5: Modes 000 and 001 give `ea = ptr + select`. Mode 100 gives `ea = ptr + select + idx`. All three request one word operand (`op_len`=1).
- R6: Mode 011 behaves as follows. With select bit 2 set, `ea = {direct_page, imm[15:0] + frame_ptr}` and `op_len`=1. Otherwise `ea = imm` and `op_len`=2 (dword). Both cases cost 2 cycles.
- R7: Mode 101 gives `ea = {direct_page, imm[15:0] + frame_ptr + idx}`, with `op_len`=1, at a cost of 3 cycles.
- R8: Mode 111 gives `ea = imm + idx` (32-bit add) with `op_len`=2.
- R9: Mode 010 with select bit 2 set returns `src_kind`=1 (register), `reg_num`={2'b00, index field} and `op_len`=0. With that bit clear it returns `src_kind`=2 (immediate) and `op_len`=1. Mode 110 returns `src_kind`=1, `reg_num`={1'b1, select} and `op_len`=0. Memory results have `src_kind`=0. When the source is not memory, `ea` reads 0.
- R10: The cycle count is: 6 for mode 000, 5 for 001, 5 for 100 plus 1 when select is nonzero, 3 for 111, and 1 for modes 010 and 110. Modes 000, 001, 100 and 111 add 1 on a page crossing. A page crossing means `ea[31:16]` differs from the unindexed base, which is the pointer for modes 000, 001 and 100 and the immediate for mode 111.
- R11: After reset, `done`, `busy`, `ptr_req`, `ea`, `cycles`, `src_kind`, `reg_num` and `op_len` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin address generation for the presented mode byte |
| mode_byte | input | 8 | Addressing-mode byte: index field, mode, select |
| imm | input | 32 | Operand word in [15:0], or full dword |
| frame_ptr | input | 16 | Frame pointer added to every offset |
| direct_page | input | 16 | Upper half of every direct-page address |
| idx_regs | input | 64 | Four 16-bit index registers, register 0 in the low bits |
| busy | output | 1 | Waiting for a direct-page pointer |
| ptr_req | output | 1 | Pointer read request |
| ptr_addr | output | 32 | Address of the pointer to read |
| ptr_ack | input | 1 | Pointer data valid this cycle |
| ptr_data | input | 32 | Pointer read from the direct page |
| done | output | 1 | One-cycle result strobe |
| src_kind | output | 2 | 0 memory, 1 register, 2 immediate |
| reg_num | output | 4 | Register source number |
| op_len | output | 2 | Operand words requested: 0 none, 1 word, 2 dword |
| ea | output | 32 | Effective address |
| cycles | output | 4 | Access cycle count |

## Verification
A wrong internal state here surfaces quickly. If the controller is stuck in its waiting state, `busy` stays high and `done` never arrives after an acknowledge; this is visible one cycle later. If captured operands are lost, the result that follows a start issued during a wait changes. A bad carry into the page bits shows as an address off by 64K together with a cycle count off by one, both on the same `done` pulse. The bench predicts every output of every cycle from its own model. It drives a mix of directed corner cases and pseudo-random mode bytes, and its pointer replies arrive with varied delays.

// File: rtl/eag_pkg.sv
package eag_pkg;

    localparam int N_IDX  = 4;
    localparam int IX_W   = 2;
    localparam int SEL_W  = 3;
    localparam int CYC_W  = 4;
    localparam int RNUM_W = 4;

    typedef enum logic [2:0] {
        M_IDX_IND = 3'd0,
        M_IND     = 3'd1,
        M_IMM_REG = 3'd2,
        M_ABS_DIR = 3'd3,
        M_IND_IDX = 3'd4,
        M_IDX_DIR = 3'd5,
        M_ACC     = 3'd6,
        M_ABS_IDX = 3'd7
    } mode_e;

    typedef enum logic [1:0] {
        SRC_MEM = 2'd0,
        SRC_REG = 2'd1,
        SRC_IMM = 2'd2
    } src_e;

    typedef enum logic [1:0] {
        LEN_NONE  = 2'd0,
        LEN_WORD  = 2'd1,
        LEN_DWORD = 2'd2
    } len_e;

    typedef struct packed {
        mode_e              mode;
        logic [IX_W-1:0]    ix;
        logic [SEL_W-1:0]   sel;
        logic               needs_ptr;
        src_e               src;
        len_e               len;
        logic [RNUM_W-1:0]  reg_num;
        logic [CYC_W-1:0]   base_cyc;
        logic               cross_counts;
        logic               sel_penalty;
    } dec_t;

endpackage

// File: rtl/eag_mode_decode.sv
module eag_mode_decode
    import eag_pkg::*;
(
    input  logic [7:0] mbyte,
    output dec_t       dec
);
    logic [IX_W-1:0]  ix;
    logic [SEL_W-1:0] sel;
    mode_e            mode;

    assign ix   = mbyte[7:6];
    assign mode = mode_e'(mbyte[5:3]);
    assign sel  = mbyte[2:0];

    always_comb begin
        dec              = '0;
        dec.mode         = mode;
        dec.ix           = ix;
        dec.sel          = sel;
        dec.src          = SRC_MEM;
        dec.len          = LEN_WORD;
        unique case (mode)
            M_IDX_IND: begin
                dec.needs_ptr    = 1'b1;
                dec.base_cyc     = CYC_W'(6);
                dec.cross_counts = 1'b1;
            end
            M_IND: begin
                dec.needs_ptr    = 1'b1;
                dec.base_cyc     = CYC_W'(5);
                dec.cross_counts = 1'b1;
            end
            M_IMM_REG: begin
                dec.base_cyc = CYC_W'(1);
                if (sel[SEL_W-1]) begin
                    dec.src     = SRC_REG;
                    dec.len     = LEN_NONE;
                    dec.reg_num = {2'b00, ix};
                end else begin
                    dec.src = SRC_IMM;
                end
            end
            M_ABS_DIR: begin
                dec.base_cyc = CYC_W'(2);
                dec.len      = sel[SEL_W-1] ? LEN_WORD : LEN_DWORD;
            end
            M_IND_IDX: begin
                dec.needs_ptr    = 1'b1;
                dec.base_cyc     = CYC_W'(5);
                dec.cross_counts = 1'b1;
                dec.sel_penalty  = 1'b1;
            end
            M_IDX_DIR: begin
                dec.base_cyc = CYC_W'(3);
            end
            M_ACC: begin
                dec.base_cyc = CYC_W'(1);
                dec.src      = SRC_REG;
                dec.len      = LEN_NONE;
                dec.reg_num  = {1'b1, sel};
            end
            default: begin
                dec.base_cyc     = CYC_W'(3);
                dec.len          = LEN_DWORD;
                dec.cross_counts = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/eag_addr_calc.sv
module eag_addr_calc
    import eag_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  mode_e                  mode,
    input  logic [SEL_W-1:0]       sel,
    input  logic [DATA_W-1:0]      idx,
    input  logic [2*DATA_W-1:0]    imm,
    input  logic [DATA_W-1:0]      fp,
    input  logic [DATA_W-1:0]      dp,
    input  logic [2*DATA_W-1:0]    ptr,
    output logic [2*DATA_W-1:0]    ptr_addr,
    output logic [2*DATA_W-1:0]    ea,
    output logic                   crossed
);
    localparam int ADDR_W = 2 * DATA_W;

    logic [DATA_W-1:0] off_fp;
    logic [DATA_W-1:0] off_fpi;
    logic [ADDR_W-1:0] sel_z;
    logic [ADDR_W-1:0] idx_z;
    logic [ADDR_W-1:0] base;

    assign off_fp  = imm[DATA_W-1:0] + fp;
    assign off_fpi = off_fp + idx;
    assign sel_z   = ADDR_W'(sel);
    assign idx_z   = ADDR_W'(idx);

    assign ptr_addr = {dp, (mode == M_IDX_IND) ? off_fpi : off_fp};

    always_comb begin
        ea   = '0;
        base = '0;
        unique case (mode)
            M_IDX_IND, M_IND: begin
                base = ptr;
                ea   = ptr + sel_z;
            end
            M_IND_IDX: begin
                base = ptr;
                ea   = ptr + sel_z + idx_z;
            end
            M_ABS_DIR: begin
                ea   = sel[SEL_W-1] ? {dp, off_fp} : imm;
                base = ea;
            end
            M_IDX_DIR: begin
                ea   = {dp, off_fpi};
                base = ea;
            end
            M_ABS_IDX: begin
                base = imm;
                ea   = imm + idx_z;
            end
            default: begin
                ea   = '0;
                base = '0;
            end
        endcase
    end

    assign crossed = (ea[ADDR_W-1:DATA_W] != base[ADDR_W-1:DATA_W]);
endmodule

// File: rtl/eag_cycle_count.sv
module eag_cycle_count
    import eag_pkg::*;
(
    input  dec_t             dec,
    input  logic             crossed,
    output logic [CYC_W-1:0] cyc
);
    logic pen_sel;
    logic pen_cross;

    assign pen_sel   = dec.sel_penalty && (dec.sel != '0);
    assign pen_cross = dec.cross_counts && crossed;
    assign cyc       = dec.base_cyc + CYC_W'(pen_sel) + CYC_W'(pen_cross);
endmodule

// File: rtl/frame_ea_gen.sv
module frame_ea_gen
    import eag_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start,
    input  logic [7:0]                mode_byte,
    input  logic [2*DATA_W-1:0]       imm,
    input  logic [DATA_W-1:0]         frame_ptr,
    input  logic [DATA_W-1:0]         direct_page,
    input  logic [N_IDX*DATA_W-1:0]   idx_regs,
    output logic                      busy,
    output logic                      ptr_req,
    output logic [2*DATA_W-1:0]       ptr_addr,
    input  logic                      ptr_ack,
    input  logic [2*DATA_W-1:0]       ptr_data,
    output logic                      done,
    output logic [1:0]                src_kind,
    output logic [RNUM_W-1:0]         reg_num,
    output logic [1:0]                op_len,
    output logic [2*DATA_W-1:0]       ea,
    output logic [CYC_W-1:0]          cycles
);
    localparam int ADDR_W = 2 * DATA_W;

    typedef enum logic {ST_IDLE = 1'b0, ST_WAIT = 1'b1} fsm_e;

    typedef struct packed {
        fsm_e              fsm;
        logic [7:0]        mbyte;
        logic [ADDR_W-1:0] imm;
        logic [DATA_W-1:0] fp;
        logic [DATA_W-1:0] dp;
        logic [DATA_W-1:0] idx;
        logic              preq;
        logic [ADDR_W-1:0] paddr;
        logic              done;
        src_e              src;
        logic [RNUM_W-1:0] rnum;
        len_e              len;
        logic [ADDR_W-1:0] ea;
        logic [CYC_W-1:0]  cyc;
    } st_t;

    st_t q, d;

    // Index register bank unpacked for selection
    logic [DATA_W-1:0] idx_arr [N_IDX];
    for (genvar g = 0; g < N_IDX; g++) begin : g_idx
        assign idx_arr[g] = idx_regs[g*DATA_W +: DATA_W];
    end

    // Operands: live inputs while idle, captured copies while waiting
    logic              idle;
    logic [7:0]        cur_mbyte;
    logic [ADDR_W-1:0] cur_imm;
    logic [DATA_W-1:0] cur_fp;
    logic [DATA_W-1:0] cur_dp;
    logic [DATA_W-1:0] cur_idx;

    assign idle      = (q.fsm == ST_IDLE);
    assign cur_mbyte = idle ? mode_byte   : q.mbyte;
    assign cur_imm   = idle ? imm         : q.imm;
    assign cur_fp    = idle ? frame_ptr   : q.fp;
    assign cur_dp    = idle ? direct_page : q.dp;
    assign cur_idx   = idle ? idx_arr[mode_byte[7:6]] : q.idx;

    dec_t              dec;
    logic [ADDR_W-1:0] paddr_c;
    logic [ADDR_W-1:0] ea_c;
    logic              crossed_c;
    logic [CYC_W-1:0]  cyc_c;

    eag_mode_decode u_dec (
        .mbyte (cur_mbyte),
        .dec   (dec)
    );

    eag_addr_calc #(.DATA_W(DATA_W)) u_calc (
        .mode     (dec.mode),
        .sel      (dec.sel),
        .idx      (cur_idx),
        .imm      (cur_imm),
        .fp       (cur_fp),
        .dp       (cur_dp),
        .ptr      (ptr_data),
        .ptr_addr (paddr_c),
        .ea       (ea_c),
        .crossed  (crossed_c)
    );

    eag_cycle_count u_cyc (
        .dec     (dec),
        .crossed (crossed_c),
        .cyc     (cyc_c)
    );

    always_comb begin
        logic finish;
        d      = q;
        d.done = 1'b0;
        finish = 1'b0;
        unique case (q.fsm)
            ST_IDLE: begin
                if (start) begin
                    d.mbyte = mode_byte;
                    d.imm   = imm;
                    d.fp    = frame_ptr;
                    d.dp    = direct_page;
                    d.idx   = cur_idx;
                    if (dec.needs_ptr) begin
                        d.fsm   = ST_WAIT;
                        d.preq  = 1'b1;
                        d.paddr = paddr_c;
                    end else begin
                        finish = 1'b1;
                    end
                end
            end
            default: begin
                if (ptr_ack) begin
                    d.fsm  = ST_IDLE;
                    d.preq = 1'b0;
                    finish = 1'b1;
                end
            end
        endcase
        if (finish) begin
            d.done = 1'b1;
            d.src  = dec.src;
            d.rnum = dec.reg_num;
            d.len  = dec.len;
            d.ea   = (dec.src == SRC_MEM) ? ea_c : '0;
            d.cyc  = cyc_c;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q     <= '0;
            q.fsm <= ST_IDLE;
            q.src <= SRC_MEM;
            q.len <= LEN_NONE;
        end else begin
            q <= d;
        end
    end

    assign busy     = (q.fsm == ST_WAIT);
    assign ptr_req  = q.preq;
    assign ptr_addr = q.paddr;
    assign done     = q.done;
    assign src_kind = q.src;
    assign reg_num  = q.rnum;
    assign op_len   = q.len;
    assign ea       = q.ea;
    assign cycles   = q.cyc;
endmodule

// File: rtl/frame_ea_gen_chk.sv
module frame_ea_gen_chk #(
    parameter int DATA_W = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic                start,
    input logic [7:0]          mode_byte,
    input logic                busy,
    input logic                ptr_req,
    input logic [2*DATA_W-1:0] ptr_addr,
    input logic                ptr_ack,
    input logic                done,
    input logic [1:0]          src_kind,
    input logic [1:0]          op_len,
    input logic [2*DATA_W-1:0] ea,
    input logic [3:0]          cycles
);
    logic ptr_mode;
    assign ptr_mode = (mode_byte[5:3] == 3'd0) || (mode_byte[5:3] == 3'd1) ||
                      (mode_byte[5:3] == 3'd4);

    a_r2_direct_done: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !ptr_mode) |=> done);

    a_r2_ptr_request: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && ptr_mode) |=> (ptr_req && busy && !done));

    a_r2_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_req && !ptr_ack) |=> (ptr_req && $stable(ptr_addr)));

    a_r2_ack_finishes: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_req && ptr_ack) |=> (done && !ptr_req && !busy));

    a_r3_no_done_while_waiting: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !ptr_ack) |=> !done);

    a_r9_nonmem_ea_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (done && src_kind != 2'd0) |-> (ea == '0));

    a_r9_reg_no_operand: assert property (@(posedge clk) disable iff (!rst_n)
        (done && src_kind == 2'd1) |-> (op_len == 2'd0));

    a_r10_cycle_range: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cycles >= 4'd1 && cycles <= 4'd7));

    a_r2_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(ea) && $stable(cycles)));
endmodule

bind frame_ea_gen frame_ea_gen_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .mode_byte (mode_byte),
    .busy      (busy),
    .ptr_req   (ptr_req),
    .ptr_addr  (ptr_addr),
    .ptr_ack   (ptr_ack),
    .done      (done),
    .src_kind  (src_kind),
    .op_len    (op_len),
    .ea        (ea),
    .cycles    (cycles)
);

// File: tb/frame_ea_gen_tb_top.sv
module frame_ea_gen_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  mode_byte = '0;
    logic [31:0] imm = '0;
    logic [15:0] frame_ptr = '0;
    logic [15:0] direct_page = '0;
    logic [63:0] idx_regs = '0;
    logic        busy, ptr_req, done;
    logic [31:0] ptr_addr, ea;
    logic        ptr_ack = 1'b0;
    logic [31:0] ptr_data = 32'hDEAD_BEEF;
    logic [1:0]  src_kind, op_len;
    logic [3:0]  reg_num, cycles;

    int n_checks = 0;
    int n_fail   = 0;
    logic [15:0] bidx [4];

    always #2 clk = ~clk;

    frame_ea_gen dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .mode_byte(mode_byte),
        .imm(imm), .frame_ptr(frame_ptr), .direct_page(direct_page),
        .idx_regs(idx_regs), .busy(busy), .ptr_req(ptr_req),
        .ptr_addr(ptr_addr), .ptr_ack(ptr_ack), .ptr_data(ptr_data),
        .done(done), .src_kind(src_kind), .reg_num(reg_num),
        .op_len(op_len), .ea(ea), .cycles(cycles)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic set_idx(input logic [15:0] a, b, c, e);
        bidx[0] = a; bidx[1] = b; bidx[2] = c; bidx[3] = e;
        idx_regs = {e, c, b, a};
    endtask

    // Behavioural reference built from the requirement text
    task automatic ref_model(input logic [7:0] mb, input logic [31:0] im,
                             input logic [15:0] fp, input logic [15:0] dp,
                             input logic [31:0] ptr,
                             output bit use_ptr, output logic [31:0] paddr,
                             output logic [31:0] e_ea, output logic [1:0] e_src,
                             output logic [3:0] e_rn, output logic [1:0] e_len,
                             output logic [3:0] e_cyc);
        int ix = int'(mb[7:6]);
        int md = int'(mb[5:3]);
        logic [2:0]  sl = mb[2:0];
        logic [15:0] iv = bidx[ix];
        logic [15:0] o16 = im[15:0] + fp;
        logic [15:0] o16i = o16 + iv;
        logic [31:0] base;
        int cy = 0;
        use_ptr = 1'b0; paddr = '0; e_ea = '0; e_src = 2'd0; e_rn = 4'd0;
        e_len = 2'd1; base = '0;
        case (md)
            0: begin use_ptr = 1; paddr = {dp, o16i}; e_ea = ptr + 32'(sl); base = ptr; cy = 6; end
            1: begin use_ptr = 1; paddr = {dp, o16};  e_ea = ptr + 32'(sl); base = ptr; cy = 5; end
            2: begin
                cy = 1;
                if (sl[2]) begin e_src = 2'd1; e_rn = {2'b00, mb[7:6]}; e_len = 2'd0; end
                else e_src = 2'd2;
            end
            3: begin
                cy = 2;
                if (sl[2]) e_ea = {dp, o16};
                else begin e_ea = im; e_len = 2'd2; end
                base = e_ea;
            end
            4: begin
                use_ptr = 1; paddr = {dp, o16}; base = ptr;
                e_ea = ptr + 32'(sl) + 32'(iv);
                cy = 5 + ((sl != 0) ? 1 : 0);
            end
            5: begin e_ea = {dp, o16i}; base = e_ea; cy = 3; end
            6: begin e_src = 2'd1; e_rn = {1'b1, sl}; e_len = 2'd0; cy = 1; end
            default: begin e_ea = im + 32'(iv); base = im; e_len = 2'd2; cy = 3; end
        endcase
        if ((md == 0 || md == 1 || md == 4 || md == 7) && (e_ea[31:16] != base[31:16]))
            cy = cy + 1;
        e_cyc = 4'(cy);
    endtask

    // One instruction, compared against the model on every clock
    task automatic run_op(input logic [7:0] mb, input logic [31:0] im,
                          input logic [15:0] fp, input logic [15:0] dp,
                          input logic [31:0] ptr, input int dly, input bit poke,
                          input string tag);
        bit use_ptr;
        logic [31:0] paddr, e_ea;
        logic [1:0]  e_src, e_len;
        logic [3:0]  e_rn, e_cyc;
        ref_model(mb, im, fp, dp, ptr, use_ptr, paddr, e_ea, e_src, e_rn, e_len, e_cyc);
        @(negedge clk);
        mode_byte = mb; imm = im; frame_ptr = fp; direct_page = dp; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (use_ptr) begin
            chk("R2", {tag, " busy"}, 32'(busy), 32'd1);
            chk("R2", {tag, " ptr_req"}, 32'(ptr_req), 32'd1);
            chk("R2", {tag, " early done"}, 32'(done), 32'd0);
            chk("R4", {tag, " ptr_addr"}, ptr_addr, paddr);
            for (int k = 0; k < dly; k++) begin
                if (poke && k == 0) begin
                    mode_byte = ~mb; imm = ~im; frame_ptr = ~fp; direct_page = ~dp;
                    start = 1'b1;
                end
                @(negedge clk);
                start = 1'b0;
                chk(poke ? "R3" : "R2", {tag, " done while waiting"}, 32'(done), 32'd0);
                chk("R2", {tag, " ptr_addr held"}, ptr_addr, paddr);
            end
            ptr_ack = 1'b1; ptr_data = ptr;
            @(negedge clk);
            ptr_ack = 1'b0; ptr_data = 32'hDEAD_BEEF;
            chk("R2", {tag, " req dropped"}, 32'(ptr_req), 32'd0);
        end
        chk("R2", {tag, " done"}, 32'(done), 32'd1);
        chk("R2", {tag, " busy low"}, 32'(busy), 32'd0);
        chk("R9", {tag, " src_kind"}, 32'(src_kind), 32'(e_src));
        chk("R9", {tag, " reg_num"}, 32'(reg_num), 32'(e_rn));
        chk("R5", {tag, " op_len"}, 32'(op_len), 32'(e_len));
        chk(poke ? "R3" : "R5", {tag, " ea"}, ea, e_ea);
        chk("R10", {tag, " cycles"}, 32'(cycles), 32'(e_cyc));
        @(negedge clk);
        chk("R2", {tag, " single done"}, 32'(done), 32'd0);
        chk("R2", {tag, " ea held"}, ea, e_ea);
    endtask

    initial begin
        #(4 * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] lf;
        set_idx(16'h0010, 16'h0200, 16'hFFFF, 16'h8000);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk("R11", "done", 32'(done), 32'd0);
        chk("R11", "busy", 32'(busy), 32'd0);
        chk("R11", "ptr_req", 32'(ptr_req), 32'd0);
        chk("R11", "ea", ea, 32'd0);
        chk("R11", "cycles", 32'(cycles), 32'd0);
        chk("R11", "src/len/reg", {26'd0, src_kind, op_len, reg_num[1:0]}, 32'd0);

        // R1 R4 R5 mode 000, index field 1, no crossing, then crossing with a wait
        run_op({2'd1, 3'd0, 3'd3}, 32'h0000_0100, 16'h0020, 16'hABCD, 32'h1234_5000, 0, 0, "R1 m000");
        run_op({2'd1, 3'd0, 3'd3}, 32'h0000_0100, 16'h0020, 16'hABCD, 32'h1234_FFFE, 3, 1, "R10 m000 cross");
        // mode 001
        run_op({2'd3, 3'd1, 3'd0}, 32'h0000_FFF0, 16'h0020, 16'h0007, 32'h00FF_0000, 1, 0, "R5 m001");
        run_op({2'd0, 3'd1, 3'd7}, 32'h0000_0000, 16'h0000, 16'h0001, 32'h0000_FFFA, 2, 1, "R10 m001 cross");
        // mode 010: register and immediate
        run_op({2'd2, 3'd2, 3'd4}, 32'h1111_2222, 16'h3333, 16'h4444, 32'h0, 0, 0, "R9 m010 reg");
        run_op({2'd2, 3'd2, 3'd1}, 32'h1111_2222, 16'h3333, 16'h4444, 32'h0, 0, 0, "R9 m010 imm");
        // mode 011
        run_op({2'd0, 3'd3, 3'd5}, 32'h0000_FFFF, 16'h0002, 16'h00AA, 32'h0, 0, 0, "R6 m011 dp");
        run_op({2'd0, 3'd3, 3'd0}, 32'h89AB_CDEF, 16'h0002, 16'h00AA, 32'h0, 0, 0, "R6 m011 abs");
        // mode 100: select zero vs nonzero, crossing
        run_op({2'd0, 3'd4, 3'd0}, 32'h0000_0040, 16'h0004, 16'h0002, 32'h0005_0000, 1, 0, "R5 m100 sel0");
        run_op({2'd2, 3'd4, 3'd5}, 32'h0000_0040, 16'h0004, 16'h0002, 32'h0005_0010, 0, 0, "R10 m100 cross");
        // mode 101 with offset wrap
        run_op({2'd3, 3'd5, 3'd2}, 32'h0000_FFF0, 16'h0020, 16'h0BAD, 32'h0, 0, 0, "R7 m101 wrap");
        // mode 110
        run_op({2'd1, 3'd6, 3'd7}, 32'h0, 16'h0, 16'h0, 32'h0, 0, 0, "R9 m110");
        // mode 111 without and with crossing
        run_op({2'd1, 3'd7, 3'd0}, 32'h0102_0304, 16'h0, 16'h0, 32'h0, 0, 0, "R8 m111");
        run_op({2'd2, 3'd7, 3'd0}, 32'h0102_FF00, 16'h0, 16'h0, 32'h0, 0, 0, "R8 m111 cross");

        // Pseudo-random mix covering R1..R10
        lf = 32'h1ACE_B00C;
        for (int n = 0; n < 80; n++) begin
            logic [31:0] a, b, c;
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]}; a = lf * 32'h9E37_79B9;
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]}; b = lf * 32'h85EB_CA6B;
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]}; c = lf * 32'hC2B2_AE35;
            set_idx(a[15:0], a[31:16], c[15:0], c[31:16]);
            run_op(b[7:0], {c[23:8], a[23:8]}, b[31:16], b[23:8], {a[7:0], c[7:0], b[15:0]},
                   int'(c[1:0]), c[2], "R1 random");
        end

        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule